// File: doc/BRIEF.md
# Two-List Sorted Merge Engine

The engine merges two lists of unsigned words, each already in ascending order, into one ascending list. Software first fills two input queues through a shared write-data bus. Each queue has its own one-cycle write strobe. Software then holds a start level high. A control state machine compares the words at the front of the two queues and moves the smaller one into a result queue. When one queue runs dry, it copies the rest of the other.

When the merge ends, the engine raises a one-cycle completion pulse, and software is expected to lower start in response. The result is then fetched one word per read strobe. Each accepted read puts the next word on a registered read-data output. While a merge is running, the engine ignores writes to the input queues and reads of the result queue.

Top module: `merge_engine`

## Requirements
- R1: While reset is asserted and right after it, `done_o` is low, `rd_data_o` is zero and all three queues are empty.
- R2: While idle, a one-cycle `wr1_en_i` or `wr2_en_i` pulse appends `wr_data_i` to the tail of queue 1 or queue 2 respectively.
- R3: A merge yields the words of both queues in ascending unsigned order. The inputs [1,3,5] and [2,4,6] give [1,2,3,4,5,6]. When the two front words are equal, the word from queue 1 goes first, and equal words are all kept.
- R4: Once either queue is exhausted, the remaining words of the other queue follow in their stored order.
- R5: A high `start_i` seen while idle begins a merge. If the result queue has room, `done_o` rises no later than N1+N2+3 clock edges after the first edge that sees start, where N1 and N2 are the queue fill levels.
- R6: `done_o` is high for exactly one cycle per merge, after which the engine is idle again.
- R7: While idle, a one-cycle `rd_en_i` pops the front result word, which appears on `rd_data_o` after the next edge. `rd_data_o` holds its value in cycles with no accepted read.
- R8: A read of an empty result queue returns zero and consumes nothing.
- R9: A write to a queue that already holds its full depth is dropped, and the stored words are not disturbed.
- R10: While a merge is running, write and read strobes have no effect: no word is added and none is popped, and `rd_data_o` holds.
- R11: Starting with both input queues empty produces a completion pulse and no result words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start level; software lowers it after done |
| wr_data_i | input | DW (32) | Word to push into an input queue |
| wr1_en_i | input | 1 | One-cycle push strobe for queue 1 |
| wr2_en_i | input | 1 | One-cycle push strobe for queue 2 |
| rd_en_i | input | 1 | One-cycle pop strobe for the result queue |
| rd_data_o | output | DW (32) | Word from the last accepted read |
| done_o | output | 1 | One-cycle merge-complete pulse |

## Verification
Some properties are checked on every cycle:
- the completion pulse is one cycle wide and returns the engine to idle;
- a start seen while idle makes the engine busy;
- reads during a merge leave the output untouched;
- an empty read yields zero;
- input fill levels never grow during a merge and never move past full;
- the cycle bound from start to completion holds.

The ordering of the merged stream, the draining of the leftover list, tie handling and the loss of an extra word written into a full queue depend on data. Only the bench's scenarios can show these, by comparing every popped word against a model merge of the lists it loaded.

// File: rtl/merge_pkg.sv
package merge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_DRAIN1,
    ST_DRAIN2,
    ST_DONE
  } merge_state_e;
endpackage

// File: rtl/merge_fifo.sv
// Synchronous queue; DEPTH must be a power of two.
module merge_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] wptr_q, rptr_q;
  logic          do_push, do_pop;

  assign count_o = wptr_q - rptr_q;
  assign empty_o = (count_o == '0);
  assign full_o  = (count_o == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rptr_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q[AW-1:0]] <= data_i;
  end
endmodule

// File: rtl/merge_ctrl.sv
module merge_ctrl
  import merge_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] a_head_i,
  input  logic          a_empty_i,
  input  logic [DW-1:0] b_head_i,
  input  logic          b_empty_i,
  input  logic          out_full_i,
  output logic          a_pop_o,
  output logic          b_pop_o,
  output logic          out_push_o,
  output logic [DW-1:0] out_data_o,
  output logic          busy_o,
  output logic          done_o
);
  merge_state_e state_q, state_d;
  logic         take_a;

  // tie goes to queue 1 to keep the merge stable
  assign take_a = (a_head_i <= b_head_i);

  always_comb begin
    state_d    = state_q;
    a_pop_o    = 1'b0;
    b_pop_o    = 1'b0;
    out_push_o = 1'b0;
    out_data_o = a_head_i;
    done_o     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_COMPARE;
      ST_COMPARE: begin
        if (a_empty_i && b_empty_i) state_d = ST_DONE;
        else if (a_empty_i)         state_d = ST_DRAIN2;
        else if (b_empty_i)         state_d = ST_DRAIN1;
        else if (!out_full_i) begin
          out_push_o = 1'b1;
          a_pop_o    = take_a;
          b_pop_o    = !take_a;
          out_data_o = take_a ? a_head_i : b_head_i;
        end
      end
      ST_DRAIN1: begin
        if (a_empty_i) state_d = ST_DONE;
        else if (!out_full_i) begin
          out_push_o = 1'b1;
          a_pop_o    = 1'b1;
        end
      end
      ST_DRAIN2: begin
        if (b_empty_i) state_d = ST_DONE;
        else if (!out_full_i) begin
          out_push_o = 1'b1;
          b_pop_o    = 1'b1;
          out_data_o = b_head_i;
        end
      end
      ST_DONE: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/merge_engine.sv
module merge_engine #(
  parameter int unsigned DW        = 32,
  parameter int unsigned IN_DEPTH  = 1024,
  parameter int unsigned OUT_DEPTH = 2048
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr1_en_i,
  input  logic          wr2_en_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o
);
  localparam int unsigned IN_CW  = $clog2(IN_DEPTH) + 1;
  localparam int unsigned OUT_CW = $clog2(OUT_DEPTH) + 1;
  localparam int unsigned NQ     = 2;

  logic [DW-1:0]    head   [NQ];
  logic [NQ-1:0]    empty, full, push, pop;
  logic [IN_CW-1:0] cnt    [NQ];
  logic [IN_CW-1:0] cnt1, cnt2;
  logic             busy;
  logic             out_push, out_pop, out_empty, out_full;
  logic [DW-1:0]    out_data, out_head;
  logic [OUT_CW-1:0] out_cnt;

  assign push[0] = !busy && wr1_en_i;
  assign push[1] = !busy && wr2_en_i;
  assign cnt1    = cnt[0];
  assign cnt2    = cnt[1];

  for (genvar g = 0; g < NQ; g++) begin : g_in
    merge_fifo #(.DW(DW), .DEPTH(IN_DEPTH)) i_in_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (push[g]),
      .data_i (wr_data_i),
      .pop_i  (pop[g]),
      .head_o (head[g]),
      .empty_o(empty[g]),
      .full_o (full[g]),
      .count_o(cnt[g])
    );
  end

  merge_ctrl #(.DW(DW)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .a_head_i  (head[0]),
    .a_empty_i (empty[0]),
    .b_head_i  (head[1]),
    .b_empty_i (empty[1]),
    .out_full_i(out_full),
    .a_pop_o   (pop[0]),
    .b_pop_o   (pop[1]),
    .out_push_o(out_push),
    .out_data_o(out_data),
    .busy_o    (busy),
    .done_o    (done_o)
  );

  assign out_pop = !busy && rd_en_i && !out_empty;

  merge_fifo #(.DW(DW), .DEPTH(OUT_DEPTH)) i_out_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (out_push),
    .data_i (out_data),
    .pop_i  (out_pop),
    .head_o (out_head),
    .empty_o(out_empty),
    .full_o (out_full),
    .count_o(out_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rd_data_o <= '0;
    else if (!busy && rd_en_i)  rd_data_o <= out_empty ? '0 : out_head;
  end
endmodule

// File: rtl/merge_engine_chk.sv
module merge_engine_chk #(
  parameter int unsigned DW        = 32,
  parameter int unsigned IN_DEPTH  = 1024,
  parameter int unsigned OUT_DEPTH = 2048,
  parameter int unsigned CW        = 11,
  parameter int unsigned OW        = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          wr1_en_i,
  input logic          wr2_en_i,
  input logic          rd_en_i,
  input logic [DW-1:0] rd_data_o,
  input logic          done_o,
  input logic          busy_i,
  input logic [CW-1:0] cnt1_i,
  input logic [CW-1:0] cnt2_i,
  input logic [OW-1:0] ocnt_i,
  input logic          oempty_i
);
  int unsigned cyc_q, lim_q;
  logic        room_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= 0;
      lim_q  <= 0;
      room_q <= 1'b0;
    end else if (!busy_i) begin
      cyc_q <= 0;
      if (start_i) begin
        lim_q  <= int'(cnt1_i) + int'(cnt2_i) + 3;
        room_q <= (int'(ocnt_i) + int'(cnt1_i) + int'(cnt2_i)) <= OUT_DEPTH;
      end
    end else begin
      cyc_q <= cyc_q + 1;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_i));
  // R5
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && start_i) |=> busy_i);
  // R5
  merge_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && room_q) |-> (cyc_q < lim_q));
  // R10
  busy_read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_en_i) |=> $stable(rd_data_o));
  // R10
  busy_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (cnt1_i <= $past(cnt1_i) && cnt2_i <= $past(cnt2_i)));
  // R8
  empty_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && rd_en_i && oempty_i) |=> (rd_data_o == '0));
  // R9
  full_drop1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && wr1_en_i && cnt1_i == CW'(IN_DEPTH)) |=> (cnt1_i == CW'(IN_DEPTH)));
  // R9
  full_drop2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && wr2_en_i && cnt2_i == CW'(IN_DEPTH)) |=> (cnt2_i == CW'(IN_DEPTH)));
endmodule

bind merge_engine merge_engine_chk #(
  .DW(DW), .IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH), .CW(IN_CW), .OW(OUT_CW)
) i_merge_engine_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .wr1_en_i (wr1_en_i),
  .wr2_en_i (wr2_en_i),
  .rd_en_i  (rd_en_i),
  .rd_data_o(rd_data_o),
  .done_o   (done_o),
  .busy_i   (busy),
  .cnt1_i   (cnt1),
  .cnt2_i   (cnt2),
  .ocnt_i   (out_cnt),
  .oempty_i (out_empty)
);

// File: tb/test_merge_engine.sv
`timescale 1ns/1ps
module test_merge_engine;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr1 = 1'b0, wr2 = 1'b0, rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        done;

  int          n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  logic [31:0] qa[$], qb[$];
  logic        chk_rd = 1'b0, rd_d = 1'b0;
  string       cur_req = "R8";

  always #2 clk = ~clk;

  merge_engine i_merge_engine (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .wr_data_i(wr_data),
    .wr1_en_i(wr1), .wr2_en_i(wr2), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .done_o(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compare each accepted read against the scoreboard
  always @(posedge clk) rd_d <= rd_en && chk_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      logic [31:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 32'd0;
      check(cur_req, rd_data, e);
    end
  end

  task automatic put(input bit sel2, input logic [31:0] d);
    @(negedge clk);
    wr_data = d; wr1 = !sel2; wr2 = sel2;
    @(negedge clk);
    wr1 = 1'b0; wr2 = 1'b0;
  endtask

  // R2: fill both queues and push the model merge to the scoreboard
  task automatic load();
    int i = 0, j = 0;
    foreach (qa[k]) put(1'b0, qa[k]);
    foreach (qb[k]) put(1'b1, qb[k]);
    while (i < qa.size() || j < qb.size()) begin
      if (j >= qb.size() || (i < qa.size() && qa[i] <= qb[j])) begin
        exp_q.push_back(qa[i]); i++;
      end else begin
        exp_q.push_back(qb[j]); j++;
      end
    end
  endtask

  task automatic wait_done(input int unsigned max_edges, input int unsigned k0);
    int unsigned k = k0;
    while (!done && k < 5000) begin
      @(negedge clk); k++;
    end
    check("R5 done seen", {31'd0, done}, 32'd1);
    check("R5 latency", {31'd0, (k <= max_edges)}, 32'd1);
    start = 1'b0;
    @(negedge clk);
    check("R6 done width", {31'd0, done}, 32'd0);
  endtask

  task automatic run();
    int unsigned n = qa.size() + qb.size();
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    wait_done(n + 3, 1);
  endtask

  task automatic read_n(input int n, input string req);
    cur_req = req;
    chk_rd = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rd_en = 1'b1;
    end
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk); chk_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] prev;
    repeat (3) @(negedge clk);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 rdata", rd_data, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 done after", {31'd0, done}, 32'd0);
    read_n(1, "R8 empty after R1");

    qa = '{1, 3, 5}; qb = '{2, 4, 6};
    load(); run(); read_n(7, "R3");

    qa = '{1, 2, 3, 10, 11}; qb = '{4};
    load(); run(); read_n(7, "R4 drain1");

    qa = '{7}; qb = '{1, 2, 3, 8, 9};
    load(); run(); read_n(7, "R4 drain2");

    qa = '{5, 5, 9}; qb = '{5, 9, 32'hFFFF_FFFF};
    load(); run(); read_n(7, "R3 ties");

    qa = '{}; qb = '{};
    load(); run(); read_n(1, "R11");

    qa = '{}; qb = '{3, 4};
    load(); run(); read_n(3, "R2 R7");

    // R10: strobes during a running merge
    qa = '{}; qb = '{};
    for (int i = 0; i < 20; i++) begin
      qa.push_back(32'(2 * i)); qb.push_back(32'(2 * i + 1));
    end
    load();
    @(negedge clk); start = 1'b1;
    repeat (3) @(negedge clk);
    prev = rd_data;
    wr_data = 32'd7; wr1 = 1'b1; wr2 = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr1 = 1'b0; wr2 = 1'b0; rd_en = 1'b0;
    check("R10 rdata hold", rd_data, prev);
    wait_done(43, 4);
    read_n(41, "R10");

    // R9: one write beyond full depth is lost
    qa = '{}; qb = '{};
    for (int i = 0; i < 1024; i++) qa.push_back(32'(i + 100));
    load();
    put(1'b0, 32'd1);
    run(); read_n(1025, "R9");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule